// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block lets an 8-bit processor with a 16-bit address bus reach ROM and RAM that are much larger than its own address space. It sits between the processor bus and the cartridge memories. Processor writes into the ROM region never reach the ROM. The block treats them as writes to its control registers: a RAM unlock byte, the switchable ROM bank, a register shared between RAM bank and upper ROM bank bits, and a mode bit. Processor reads in the ROM and external RAM regions are turned into wide physical addresses. Writes to external RAM become a registered write strobe, together with the address and the data.

A static flavour input picks one of three controller variants. Type 1 has a 5-bit low bank field. It also has a mode bit that decides whether the 0x4000–0x5FFF register feeds ROM bank bits [6:5] or the RAM bank. Type 3 has a 7-bit bank. Type 5 has a 9-bit bank, split across two write regions, and accepts bank 0. The storage arrays are outside the block. The flavour may change only while reset is asserted.

Top module: `cart_bank_ctrl`

## Requirements
- R1: Reset is synchronous and active high. It leaves ROM bank = 1, RAM bank = 0, RAM unlock byte = 0, mode = 0 and the write strobe low.
- R2: A write to 0x0000–0x1FFF stores the whole byte as the unlock byte. External RAM writes produce a strobe only while that byte equals exactly 0x0A.
- R3: Type 1 (flavour = 0): a write to 0x2000–0x3FFF sets the bank to data[4:0] with all higher bank bits cleared. Only an all-zero byte turns into bank 1, so data 0x20 gives bank 0.
- R4: Type 3 (flavour = 1): a write to 0x2000–0x3FFF sets the bank to data[6:0] with bits above cleared. Only an all-zero byte turns into bank 1.
- R5: Type 5 (flavour = 2): a write to 0x2000–0x2FFF replaces bank bits [7:0]. A write to 0x3000–0x3FFF replaces bank bit 8 with data[0]. Bank 0 is kept as written.
- R6: A write to 0x4000–0x5FFF in type 1 with mode 0 places data[1:0] in ROM bank bits [6:5] and leaves the other bits as they were. In all other cases it loads the 8-bit RAM bank register.
- R7: A write to 0x6000–0x7FFF loads the mode bit from data[0].
- R8: A read of 0x0000–0x3FFF asserts rom_cs with rom_addr = CPU address. A read of 0x4000–0x7FFF asserts rom_cs with rom_addr = (address − 0x4000) + bank × 0x4000. Both are combinational from the current state.
- R9: A read of 0xA000–0xBFFF asserts ram_cs with ram_addr = (address − 0xA000) + (RAM bank mod 16) × 0x2000. In type 1 with mode 0, the bank term is zero.
- R10: Control registers change only on a write strobe at an address below 0x8000. Writes at or above 0x8000 leave all banking unchanged.
- R11: In the cycle after each qualifying RAM write edge, ram_we is high for exactly one cycle and carries the mapped address and data. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flavour | input | 2 | Controller variant: 0 type 1, 1 type 3, 2 type 5 |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_wr | input | 1 | Processor write strobe, one cycle per write |
| cpu_rd | input | 1 | Processor read strobe |
| rom_cs | output | 1 | ROM read select |
| rom_addr | output | 23 | Physical ROM address |
| ram_cs | output | 1 | External RAM read select |
| ram_addr | output | 17 | Physical RAM address for the current access |
| ram_we | output | 1 | Registered RAM write enable |
| ram_wr_addr | output | 17 | RAM address for the strobed write |
| ram_wr_data | output | 8 | Data for the strobed write |

## Verification
The assertions check the following on every cycle: the reset state, the bank-1 substitution after a zero byte in types 1 and 3, that a type 5 high-bit write keeps bits [7:0], that mode-0 upper writes land in bits [6:5], that the mode bit loads, that writes at or above 0x8000 leave the registers alone, that a strobe never appears without an unlock value of 0x0A, and that the fixed ROM region never carries bank bits. The bench scenarios are the only place that shows the full address arithmetic under each flavour. That includes the 0x20 and 0x80 bytes that give bank 0, the type 1 mode switch that reroutes the shared register and drops the RAM bank, and the relocking of RAM by any byte other than 0x0A.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    localparam int CPU_AW     = 16;
    localparam int BYTE_W     = 8;
    localparam int ROM_WIN_W  = 14;
    localparam int RAM_WIN_W  = 13;
    localparam int ROM_BANK_W = 9;
    localparam int RAM_BANK_W = 4;
    localparam int ROM_AW     = ROM_BANK_W + ROM_WIN_W;
    localparam int RAM_AW     = RAM_BANK_W + RAM_WIN_W;
    localparam int T1_LOW_W   = 5;
    localparam int T3_LOW_W   = 7;
    localparam logic [BYTE_W-1:0] RAM_KEY = 8'h0A;

    typedef enum logic [1:0] {
        FLV_T1 = 2'd0,
        FLV_T3 = 2'd1,
        FLV_T5 = 2'd2
    } flavour_e;

    typedef enum logic [2:0] {
        WIN_UNLOCK,
        WIN_BANK_LO,
        WIN_BANK_HI,
        WIN_SHARED,
        WIN_MODE,
        WIN_XRAM,
        WIN_OTHER
    } win_e;

    typedef struct packed {
        logic [ROM_BANK_W-1:0] rom_bank;
        logic [BYTE_W-1:0]     ram_bank;
        logic [BYTE_W-1:0]     unlock;
        logic                  mode;
    } ctl_regs_t;

    function automatic win_e decode_win(input logic [CPU_AW-1:0] a);
        win_e w;
        unique case (a[15:13])
            3'b000:  w = WIN_UNLOCK;
            3'b001:  w = a[12] ? WIN_BANK_HI : WIN_BANK_LO;
            3'b010:  w = WIN_SHARED;
            3'b011:  w = WIN_MODE;
            3'b101:  w = WIN_XRAM;
            default: w = WIN_OTHER;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/mbc_regs.sv
module mbc_regs
    import mbc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  flavour_e            flavour,
    input  logic                wr,
    input  logic [CPU_AW-1:0]   addr,
    input  logic [BYTE_W-1:0]   wdata,
    output ctl_regs_t           regs
);

    win_e      win;
    ctl_regs_t nxt;
    logic      ctl_wr;

    assign win    = decode_win(addr);
    assign ctl_wr = wr && !addr[15];

    always_comb begin
        nxt = regs;
        if (ctl_wr) begin
            unique case (win)
                WIN_UNLOCK: nxt.unlock = wdata;
                WIN_BANK_LO, WIN_BANK_HI: begin
                    unique case (flavour)
                        FLV_T1: begin
                            nxt.rom_bank = '0;
                            nxt.rom_bank[T1_LOW_W-1:0] = wdata[T1_LOW_W-1:0];
                            if (wdata == '0) nxt.rom_bank[0] = 1'b1;
                        end
                        FLV_T3: begin
                            nxt.rom_bank = '0;
                            nxt.rom_bank[T3_LOW_W-1:0] = wdata[T3_LOW_W-1:0];
                            if (wdata == '0) nxt.rom_bank[0] = 1'b1;
                        end
                        FLV_T5: begin
                            if (win == WIN_BANK_LO) nxt.rom_bank[BYTE_W-1:0] = wdata;
                            else                    nxt.rom_bank[BYTE_W]     = wdata[0];
                        end
                        default: nxt = regs;
                    endcase
                end
                WIN_SHARED: begin
                    if (flavour == FLV_T1 && !regs.mode)
                        nxt.rom_bank[T1_LOW_W+1:T1_LOW_W] = wdata[1:0];
                    else
                        nxt.ram_bank = wdata;
                end
                WIN_MODE: nxt.mode = wdata[0];
                default:  nxt = regs;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs.rom_bank <= ROM_BANK_W'(1);
            regs.ram_bank <= '0;
            regs.unlock   <= '0;
            regs.mode     <= 1'b0;
        end else begin
            regs <= nxt;
        end
    end

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (regs.rom_bank == ROM_BANK_W'(1) && regs.ram_bank == '0 &&
                        regs.unlock == '0 && !regs.mode));

    // R3 / R4
    a_r3_zero_byte_bank1: assert property (@(posedge clk) disable iff (rst)
        (wr && addr[15:13] == 3'b001 && wdata == '0 && flavour != FLV_T5)
        |=> regs.rom_bank == ROM_BANK_W'(1));

    // R5
    a_r5_hi_keeps_low: assert property (@(posedge clk) disable iff (rst)
        (wr && addr[15:12] == 4'h3 && flavour == FLV_T5)
        |=> regs.rom_bank[BYTE_W-1:0] == $past(regs.rom_bank[BYTE_W-1:0]));

    // R6
    a_r6_upper_bits: assert property (@(posedge clk) disable iff (rst)
        (wr && addr[15:13] == 3'b010 && flavour == FLV_T1 && !regs.mode)
        |=> regs.rom_bank[T1_LOW_W+1:T1_LOW_W] == $past(wdata[1:0]));

    // R7
    a_r7_mode_load: assert property (@(posedge clk) disable iff (rst)
        (wr && addr[15:13] == 3'b011) |=> regs.mode == $past(wdata[0]));

    // R10
    a_r10_high_write_inert: assert property (@(posedge clk) disable iff (rst)
        (wr && addr[15]) |=> $stable(regs));

endmodule

// File: rtl/mbc_map.sv
module mbc_map
    import mbc_pkg::*;
(
    input  flavour_e            flavour,
    input  ctl_regs_t           regs,
    input  logic [CPU_AW-1:0]   addr,
    input  logic                rd,
    output logic                rom_cs,
    output logic [ROM_AW-1:0]   rom_addr,
    output logic                ram_cs,
    output logic [RAM_AW-1:0]   ram_addr
);

    logic [ROM_BANK_W-1:0] rom_sel;
    logic [RAM_BANK_W-1:0] ram_sel;
    logic                  ram_bank_forced0;

    assign rom_sel          = addr[ROM_WIN_W] ? regs.rom_bank : '0;
    assign ram_bank_forced0 = (flavour == FLV_T1) && !regs.mode;
    assign ram_sel          = ram_bank_forced0 ? '0 : regs.ram_bank[RAM_BANK_W-1:0];

    assign rom_addr = {rom_sel, addr[ROM_WIN_W-1:0]};
    assign ram_addr = {ram_sel, addr[RAM_WIN_W-1:0]};
    assign rom_cs   = rd && !addr[15];
    assign ram_cs   = rd && (decode_win(addr) == WIN_XRAM);

endmodule

// File: rtl/mbc_wr_gate.sv
module mbc_wr_gate
    import mbc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [CPU_AW-1:0]   addr,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic [BYTE_W-1:0]   unlock,
    input  logic [RAM_AW-1:0]   map_addr,
    output logic                we,
    output logic [RAM_AW-1:0]   we_addr,
    output logic [BYTE_W-1:0]   we_data
);

    logic hit;
    assign hit = wr && (decode_win(addr) == WIN_XRAM) && (unlock == RAM_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            we      <= 1'b0;
            we_addr <= '0;
            we_data <= '0;
        end else begin
            we <= hit;
            if (hit) begin
                we_addr <= map_addr;
                we_data <= wdata;
            end
        end
    end

    // R2
    a_r2_needs_key: assert property (@(posedge clk) disable iff (rst)
        we |-> $past(unlock) == RAM_KEY);

    // R11
    a_r11_from_ram_write: assert property (@(posedge clk) disable iff (rst)
        we |-> ($past(wr) && $past(addr[15:13]) == 3'b101));

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import mbc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           flavour,
    input  logic [CPU_AW-1:0]    cpu_addr,
    input  logic [BYTE_W-1:0]    cpu_wdata,
    input  logic                 cpu_wr,
    input  logic                 cpu_rd,
    output logic                 rom_cs,
    output logic [ROM_AW-1:0]    rom_addr,
    output logic                 ram_cs,
    output logic [RAM_AW-1:0]    ram_addr,
    output logic                 ram_we,
    output logic [RAM_AW-1:0]    ram_wr_addr,
    output logic [BYTE_W-1:0]    ram_wr_data
);

    flavour_e  flv;
    ctl_regs_t regs;

    assign flv = flavour_e'(flavour);

    mbc_regs u_regs (
        .clk(clk), .rst(rst), .flavour(flv), .wr(cpu_wr),
        .addr(cpu_addr), .wdata(cpu_wdata), .regs(regs)
    );

    mbc_map u_map (
        .flavour(flv), .regs(regs), .addr(cpu_addr), .rd(cpu_rd),
        .rom_cs(rom_cs), .rom_addr(rom_addr), .ram_cs(ram_cs), .ram_addr(ram_addr)
    );

    mbc_wr_gate u_gate (
        .clk(clk), .rst(rst), .wr(cpu_wr), .addr(cpu_addr), .wdata(cpu_wdata),
        .unlock(regs.unlock), .map_addr(ram_addr),
        .we(ram_we), .we_addr(ram_wr_addr), .we_data(ram_wr_data)
    );

    // R8
    a_r8_fixed_region: assert property (@(posedge clk) disable iff (rst)
        (rom_cs && !cpu_addr[14]) |-> rom_addr[ROM_AW-1:ROM_WIN_W] == '0);

endmodule

// File: tb/sim_cart_bank_ctrl.sv
module sim_cart_bank_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  flavour = 2'd0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic        rom_cs, ram_cs, ram_we;
    logic [22:0] rom_addr;
    logic [16:0] ram_addr, ram_wr_addr;
    logic [7:0]  ram_wr_data;

    always #4 clk = ~clk;

    cart_bank_ctrl u0 (
        .clk(clk), .rst(rst), .flavour(flavour), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .rom_cs(rom_cs), .rom_addr(rom_addr), .ram_cs(ram_cs), .ram_addr(ram_addr),
        .ram_we(ram_we), .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data)
    );

    typedef struct packed {
        logic        is_rd;
        logic        rom_cs;
        logic [22:0] rom_addr;
        logic        ram_cs;
        logic [16:0] ram_addr;
        logic        we;
        logic [16:0] waddr;
        logic [7:0]  wdata;
    } item_t;

    item_t q_item[$];
    string q_req[$];
    int checks = 0;
    int errors = 0;

    int m_bank, m_rbank, m_unlock, m_mode;

    function automatic int exp_ram(input int a);
        int b;
        b = (flavour == 2'd0 && m_mode == 0) ? 0 : (m_rbank % 16);
        return ((a - 'hA000) + b * 'h2000) & 'h1FFFF;
    endfunction

    task automatic model_reset();
        m_bank = 1; m_rbank = 0; m_unlock = 0; m_mode = 0;
    endtask

    task automatic model_write(input int a, input int d);
        if (a < 'h2000) m_unlock = d;
        else if (a < 'h4000) begin
            if (flavour == 2'd0) m_bank = (d == 0) ? 1 : (d & 'h1F);
            else if (flavour == 2'd1) m_bank = (d == 0) ? 1 : (d & 'h7F);
            else if (a < 'h3000) m_bank = (m_bank & 'h100) | d;
            else m_bank = (m_bank & 'hFF) | ((d & 1) << 8);
        end else if (a < 'h6000) begin
            if (flavour == 2'd0 && m_mode == 0) m_bank = (m_bank & ~'h60) | ((d & 3) << 5);
            else m_rbank = d;
        end else if (a < 'h8000) m_mode = d & 1;
    endtask

    task automatic op(input logic rd, input logic wr, input int a, input int d, input string req);
        item_t it;
        @(negedge clk);
        cpu_rd = rd; cpu_wr = wr; cpu_addr = a[15:0]; cpu_wdata = d[7:0];
        it = '0;
        it.is_rd = rd;
        if (rd && a < 'h8000) begin
            it.rom_cs = 1'b1;
            it.rom_addr = (a < 'h4000) ? 23'(a) : 23'((a - 'h4000) + m_bank * 'h4000);
        end
        if (rd && a >= 'hA000 && a < 'hC000) begin
            it.ram_cs = 1'b1;
            it.ram_addr = 17'(exp_ram(a));
        end
        if (wr && a >= 'hA000 && a < 'hC000 && m_unlock == 'h0A) begin
            it.we = 1'b1;
            it.waddr = 17'(exp_ram(a));
            it.wdata = d[7:0];
        end
        q_item.push_back(it);
        q_req.push_back(req);
        if (wr) model_write(a, d);
    endtask

    task automatic rd_op(input int a, input string req); op(1'b1, 1'b0, a, 0, req); endtask
    task automatic wr_op(input int a, input int d, input string req); op(1'b0, 1'b1, a, d, req); endtask

    task automatic do_reset(input logic [1:0] f);
        @(negedge clk);
        rst = 1'b1; cpu_rd = 1'b0; cpu_wr = 1'b0; flavour = f;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // monitor: compares each queued item one step after the edge it belongs to
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_item.size() > 0) begin
                item_t it;
                string rq;
                it = q_item.pop_front();
                rq = q_req.pop_front();
                chk(rq, "ram_we", int'(ram_we), int'(it.we));
                if (it.we) begin
                    chk(rq, "ram_wr_addr", int'(ram_wr_addr), int'(it.waddr));
                    chk(rq, "ram_wr_data", int'(ram_wr_data), int'(it.wdata));
                end
                if (it.is_rd) begin
                    chk(rq, "rom_cs", int'(rom_cs), int'(it.rom_cs));
                    chk(rq, "ram_cs", int'(ram_cs), int'(it.ram_cs));
                    if (it.rom_cs) chk(rq, "rom_addr", int'(rom_addr), int'(it.rom_addr));
                    if (it.ram_cs) chk(rq, "ram_addr", int'(ram_addr), int'(it.ram_addr));
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // ---------- type 1 ----------
        do_reset(2'd0);
        #1;
        chk("R1", "ram_we in reset", int'(ram_we), 0);
        rd_op('h4123, "R1");            // bank 1 after reset
        rd_op('h0123, "R8");            // fixed region
        rd_op('hA010, "R1");            // RAM bank 0
        wr_op('hA000, 'h11, "R2");      // locked: no strobe
        wr_op('h0000, 'h0A, "R2");
        wr_op('hA005, 'h5A, "R11");     // strobe next cycle
        op(1'b0, 1'b0, 0, 0, "R11");    // strobe gone
        wr_op('h1FFF, 'h0B, "R2");
        wr_op('hA005, 'h66, "R2");      // relocked
        wr_op('h0000, 'h0A, "R2");
        wr_op('h2000, 'h00, "R3");
        rd_op('h4000, "R3");            // bank 1
        wr_op('h2000, 'h13, "R3");
        wr_op('h4000, 'h03, "R6");      // bits 6:5
        rd_op('h7FFF, "R6");            // bank 0x73
        wr_op('h3FFF, 'h05, "R3");      // upper bits cleared
        rd_op('h4001, "R3");
        wr_op('h2000, 'h20, "R3");      // nonzero byte -> bank 0
        rd_op('h4002, "R3");
        wr_op('h6000, 'h01, "R7");      // mode 1
        wr_op('h5FFF, 'h03, "R6");      // now RAM bank
        rd_op('hB000, "R9");
        wr_op('hB004, 'hC3, "R11");     // banked write address
        rd_op('h4003, "R6");            // ROM bank unchanged
        wr_op('h7000, 'h00, "R7");      // back to mode 0
        rd_op('hB000, "R9");            // bank term dropped
        wr_op('h9000, 'h55, "R10");
        wr_op('hC000, 'h55, "R10");
        wr_op('hA100, 'h00, "R10");
        rd_op('h4004, "R10");           // bank still 0
        rd_op('h8000, "R8");            // neither select
        // ---------- type 3 ----------
        do_reset(2'd1);
        rd_op('h4000, "R1");
        wr_op('h2000, 'h7F, "R4");
        rd_op('h7000, "R4");
        wr_op('h2000, 'h00, "R4");
        rd_op('h4010, "R4");
        wr_op('h2000, 'h85, "R4");
        rd_op('h4020, "R4");
        wr_op('h3000, 'h80, "R4");      // bank 0
        rd_op('h4030, "R4");
        wr_op('h4000, 'h05, "R6");      // RAM bank in mode 0
        rd_op('hA000, "R9");
        rd_op('h4040, "R6");
        // ---------- type 5 ----------
        do_reset(2'd2);
        wr_op('h2000, 'h00, "R5");
        rd_op('h4000, "R5");            // bank 0 kept
        wr_op('h3000, 'h01, "R5");
        rd_op('h4000, "R5");
        wr_op('h2FFF, 'hAB, "R5");
        rd_op('h5555, "R5");
        wr_op('h3FFF, 'hFE, "R5");
        rd_op('h7FFF, "R5");
        wr_op('h4000, 'h1F, "R6");
        rd_op('hBFFF, "R9");
        wr_op('h0000, 'h0A, "R2");
        wr_op('hBFFF, 'h77, "R11");
        repeat (3) op(1'b0, 1'b0, 0, 0, "R11");
        @(negedge clk);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule